// File: doc/BRIEF.md
# Integer Execute Unit with Multiply Result Registers

This block is the arithmetic stage of a small 32-bit load/store processor. It takes two register operands, a 16-bit immediate, a 5-bit shift count and an operation code that the decode stage has already resolved. It returns the 32-bit value to be written to the destination register. The result path is purely combinational, so the value is valid in the same cycle the operands are presented.

The block also owns the two 32-bit registers that receive a full 64-bit product. A signed or unsigned multiply loads the upper half into HI and the lower half into LO on the clock edge, but only when the write enable is high. Two move operations read HI and LO back through the normal result port. Each immediate operation picks its own extension of the 16-bit field, and the choice differs between operations.

Top module: `int_exec_unit`

## Requirements
- R1: Codes 0 (add), 1 (subtract) and 11 (add immediate) wrap modulo 2^32 and never trap. Code 11 adds the immediate sign-extended from bit 15.
- R2: Codes 2, 3 and 4 give the bitwise AND, OR and XOR of operands A and B. Codes 12, 13 and 14 do the same with operand A and the immediate zero-extended to 32 bits.
- R3: Code 5 shifts operand B left by the shift-count input. Code 6 shifts operand B right by the shift-count input with zero fill.
- R4: Code 7 shifts operand B left, and code 8 shifts it right logically, by the amount in bits 4:0 of operand A. Bits 31:5 of operand A are ignored.
- R5: Code 9 returns 1 if A is less than B as signed two's-complement values and 0 otherwise. Code 10 makes the same comparison on unsigned values.
- R6: Code 15 returns 1 if signed A is less than the sign-extended immediate. Code 16 returns 1 if unsigned A is less than the zero-extended immediate. Both return 0 otherwise.
- R7: Code 17 returns the immediate in bits 31:16 with bits 15:0 zero.
- R8: Code 18 (signed) or 19 (unsigned) with write enable high loads the upper 32 bits of the 64-bit product of A and B into HI and the lower 32 bits into LO at the next rising clock edge.
- R9: Code 20 returns the current HI value and code 21 returns the current LO value.
- R10: HI and LO are zero after reset. They change only on a multiply code with write enable high. A multiply with write enable low leaves both unchanged.
- R11: Codes 18 and 19, and every code from 22 to 31, return a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; HI and LO update on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Decoded operation code |
| src_a_i | input | 32 | First register operand (variable shift amount source) |
| src_b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Fixed shift count |
| wr_en_i | input | 1 | Qualifies the multiply write into HI and LO |
| result_o | output | 32 | Destination register value |

## Verification
The bench targets the places where the extension rule changes from one operation to the next. It uses an unsigned immediate compare with a 0xFFFF field, which a sign-extending design would answer the wrong way. It also uses an AND-immediate with bit 15 set, which would leak ones into the upper half. Right shifts by 31 of a negative word catch an arithmetic fill, and variable shifts with high garbage bits in operand A catch a design that uses more than five bits. Multiplies with a negative operand expose signed and unsigned product mix-ups in HI. A multiply with the enable low shows up as a changed HI or LO on the next move-from.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
   localparam int OP_W = 5;

   localparam logic [OP_W-1:0] OP_ADD   = 5'd0;
   localparam logic [OP_W-1:0] OP_SUB   = 5'd1;
   localparam logic [OP_W-1:0] OP_AND   = 5'd2;
   localparam logic [OP_W-1:0] OP_OR    = 5'd3;
   localparam logic [OP_W-1:0] OP_XOR   = 5'd4;
   localparam logic [OP_W-1:0] OP_SHLI  = 5'd5;
   localparam logic [OP_W-1:0] OP_SHRI  = 5'd6;
   localparam logic [OP_W-1:0] OP_SHLR  = 5'd7;
   localparam logic [OP_W-1:0] OP_SHRR  = 5'd8;
   localparam logic [OP_W-1:0] OP_LTS   = 5'd9;
   localparam logic [OP_W-1:0] OP_LTU   = 5'd10;
   localparam logic [OP_W-1:0] OP_ADDK  = 5'd11;
   localparam logic [OP_W-1:0] OP_ANDK  = 5'd12;
   localparam logic [OP_W-1:0] OP_ORK   = 5'd13;
   localparam logic [OP_W-1:0] OP_XORK  = 5'd14;
   localparam logic [OP_W-1:0] OP_LTSK  = 5'd15;
   localparam logic [OP_W-1:0] OP_LTUK  = 5'd16;
   localparam logic [OP_W-1:0] OP_UPK   = 5'd17;
   localparam logic [OP_W-1:0] OP_MULS  = 5'd18;
   localparam logic [OP_W-1:0] OP_MULU  = 5'd19;
   localparam logic [OP_W-1:0] OP_RDHI  = 5'd20;
   localparam logic [OP_W-1:0] OP_RDLO  = 5'd21;
endpackage

// File: rtl/iexu_shift.sv
module iexu_shift #(
   parameter int XLEN   = 32,
   parameter bit BARREL = 1'b1,
   localparam int SH_W  = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] data_i,
   input  logic [SH_W-1:0] amt_i,
   input  logic            left_i,
   output logic [XLEN-1:0] data_o
);
   if ((1 << SH_W) != XLEN) begin : g_chk_pow2
      $error("iexu_shift: XLEN must be a power of two");
   end

   if (BARREL) begin : g_barrel
      logic [XLEN-1:0] rev_in;
      logic [XLEN-1:0] rev_out;
      logic [XLEN-1:0] stage [SH_W+1];

      for (genvar i = 0; i < XLEN; i++) begin : g_rev
         assign rev_in[i]  = data_i[XLEN-1-i];
         assign rev_out[i] = stage[SH_W][XLEN-1-i];
      end

      assign stage[0] = left_i ? data_i : rev_in;

      for (genvar k = 0; k < SH_W; k++) begin : g_stage
         assign stage[k+1] = amt_i[k] ? (stage[k] << (1 << k)) : stage[k];
      end

      assign data_o = left_i ? stage[SH_W] : rev_out;
   end else begin : g_operator
      assign data_o = left_i ? (data_i << amt_i) : (data_i >> amt_i);
   end
endmodule

// File: rtl/iexu_mul.sv
module iexu_mul #(
   parameter int XLEN = 32,
   localparam int PW  = 2 * XLEN
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic            signed_i,
   output logic [PW-1:0]   prod_o
);
   logic [PW-1:0] a_w;
   logic [PW-1:0] b_w;

   assign a_w = {{XLEN{signed_i & a_i[XLEN-1]}}, a_i};
   assign b_w = {{XLEN{signed_i & b_i[XLEN-1]}}, b_i};

   assign prod_o = a_w * b_w;
endmodule

// File: rtl/iexu_hilo.sv
module iexu_hilo #(
   parameter int XLEN = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [2*XLEN-1:0] prod_i,
   output logic [XLEN-1:0]   hi_o,
   output logic [XLEN-1:0]   lo_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_o <= '0;
         lo_o <= '0;
      end else if (load_i) begin
         hi_o <= prod_i[2*XLEN-1:XLEN];
         lo_o <= prod_i[XLEN-1:0];
      end
   end

   AST_HILO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> ($stable(hi_o) && $stable(lo_o))); // R10

   AST_HILO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> ({hi_o, lo_o} == $past(prod_i))); // R8
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
   import iexu_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int IMM_W  = 16,
   parameter bit BARREL = 1'b1,
   localparam int SH_W  = $clog2(XLEN),
   localparam int EXT_W = XLEN - IMM_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [OP_W-1:0]  op_i,
   input  logic [XLEN-1:0]  src_a_i,
   input  logic [XLEN-1:0]  src_b_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [SH_W-1:0]  shamt_i,
   input  logic             wr_en_i,
   output logic [XLEN-1:0]  result_o
);
   if (IMM_W >= XLEN) begin : g_chk_imm
      $error("int_exec_unit: IMM_W must be narrower than XLEN");
   end

   logic [XLEN-1:0]   imm_sx;
   logic [XLEN-1:0]   imm_zx;
   logic [XLEN-1:0]   sh_out;
   logic [SH_W-1:0]   sh_amt;
   logic              sh_left;
   logic              is_mul;
   logic [2*XLEN-1:0] prod;
   logic [XLEN-1:0]   hi_q;
   logic [XLEN-1:0]   lo_q;

   assign imm_sx = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
   assign imm_zx = {{EXT_W{1'b0}}, imm_i};

   // shift control: register forms take the amount from operand A
   assign sh_amt  = (op_i == OP_SHLR || op_i == OP_SHRR) ? src_a_i[SH_W-1:0] : shamt_i;
   assign sh_left = (op_i == OP_SHLI || op_i == OP_SHLR);

   iexu_shift #(.XLEN(XLEN), .BARREL(BARREL)) u_shift (
      .data_i (src_b_i),
      .amt_i  (sh_amt),
      .left_i (sh_left),
      .data_o (sh_out)
   );

   iexu_mul #(.XLEN(XLEN)) u_mul (
      .a_i      (src_a_i),
      .b_i      (src_b_i),
      .signed_i (op_i == OP_MULS),
      .prod_o   (prod)
   );

   assign is_mul = (op_i == OP_MULS || op_i == OP_MULU);

   iexu_hilo #(.XLEN(XLEN)) u_hilo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (is_mul && wr_en_i),
      .prod_i (prod),
      .hi_o   (hi_q),
      .lo_o   (lo_q)
   );

   always_comb begin
      result_o = '0;
      unique case (op_i)
         OP_ADD:  result_o = src_a_i + src_b_i;
         OP_SUB:  result_o = src_a_i - src_b_i;
         OP_AND:  result_o = src_a_i & src_b_i;
         OP_OR:   result_o = src_a_i | src_b_i;
         OP_XOR:  result_o = src_a_i ^ src_b_i;
         OP_SHLI, OP_SHRI, OP_SHLR, OP_SHRR: result_o = sh_out;
         OP_LTS:  result_o = {{(XLEN-1){1'b0}}, ($signed(src_a_i) < $signed(src_b_i))};
         OP_LTU:  result_o = {{(XLEN-1){1'b0}}, (src_a_i < src_b_i)};
         OP_ADDK: result_o = src_a_i + imm_sx;
         OP_ANDK: result_o = src_a_i & imm_zx;
         OP_ORK:  result_o = src_a_i | imm_zx;
         OP_XORK: result_o = src_a_i ^ imm_zx;
         OP_LTSK: result_o = {{(XLEN-1){1'b0}}, ($signed(src_a_i) < $signed(imm_sx))};
         OP_LTUK: result_o = {{(XLEN-1){1'b0}}, (src_a_i < imm_zx)};
         OP_UPK:  result_o = {imm_i, {EXT_W{1'b0}}};
         OP_RDHI: result_o = hi_q;
         OP_RDLO: result_o = lo_q;
         default: result_o = '0;
      endcase
   end

   AST_CMP_BOOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_LTS || op_i == OP_LTU || op_i == OP_LTSK || op_i == OP_LTUK)
      |-> (result_o[XLEN-1:1] == '0)); // R5

   AST_UPPER_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_UPK) |-> (result_o[EXT_W-1:0] == '0)); // R7

   AST_SHIFT_ZERO_AMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((op_i == OP_SHLI || op_i == OP_SHRI) && shamt_i == '0) |-> (result_o == src_b_i)); // R3

   AST_IDLE_RESULT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i > OP_RDLO || is_mul) |-> (result_o == '0)); // R11
endmodule

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  op = '0;
   logic [31:0] a = '0;
   logic [31:0] b = '0;
   logic [15:0] imm = '0;
   logic [4:0]  sh = '0;
   logic        we = 1'b0;
   logic [31:0] res;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   logic [31:0] m_hi = '0;
   logic [31:0] m_lo = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   int_exec_unit uut (
      .clk_i(clk), .rst_ni(rst_n), .op_i(op), .src_a_i(a), .src_b_i(b),
      .imm_i(imm), .shamt_i(sh), .wr_en_i(we), .result_o(res)
   );

   function automatic string req_of(input int code);
      case (code)
         0, 1, 11:             return "R1";
         2, 3, 4, 12, 13, 14:  return "R2";
         5, 6:                 return "R3";
         7, 8:                 return "R4";
         9, 10:                return "R5";
         15, 16:               return "R6";
         17:                   return "R7";
         20, 21:               return "R9";
         default:              return "R11";
      endcase
   endfunction

   function automatic logic [31:0] model(input int code, input logic [31:0] x,
                                         input logic [31:0] y, input logic [15:0] k,
                                         input int s);
      int sx, sy, sk;
      longint unsigned ux, uy, uk;
      sx = x; sy = y; sk = int'(shortint'(k));
      ux = x; uy = y; uk = k;
      case (code)
         0:  return x + y;
         1:  return x - y;
         2:  return x & y;
         3:  return x | y;
         4:  return x ^ y;
         5:  return y << s;
         6:  return y >> s;
         7:  return y << (x % 32);
         8:  return y >> (x % 32);
         9:  return (sx < sy) ? 32'd1 : 32'd0;
         10: return (ux < uy) ? 32'd1 : 32'd0;
         11: return x + sk;
         12: return x & uk[31:0];
         13: return x | uk[31:0];
         14: return x ^ uk[31:0];
         15: return (sx < sk) ? 32'd1 : 32'd0;
         16: return (ux < uk) ? 32'd1 : 32'd0;
         17: return uk[31:0] * 65536;
         20: return m_hi;
         21: return m_lo;
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] exp);
      compared++;
      if (res !== exp) begin
         mismatched++;
         $display("FAIL %s op=%0d actual=%h expected=%h", tag, op, res, exp);
      end
   endtask

   task automatic step(input int code, input logic [31:0] x, input logic [31:0] y,
                       input logic [15:0] k, input int s, input bit w);
      longint sp;
      longint unsigned up;
      @(negedge clk);
      op = code[4:0]; a = x; b = y; imm = k; sh = s[4:0]; we = w;
      #1;
      check(req_of(code), model(code, x, y, k, s));
      @(posedge clk);
      if (w && code == 18) begin
         // R8 signed product
         sp = longint'(int'(x)) * longint'(int'(y));
         m_hi = sp[63:32]; m_lo = sp[31:0];
      end else if (w && code == 19) begin
         // R8 unsigned product
         up = longint'({32'd0, x}) * longint'({32'd0, y});
         m_hi = up[63:32]; m_lo = up[31:0];
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      mismatched++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: multiply attempted during reset must not load
      op = 5'd18; a = 32'h7; b = 32'h9; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      rst_n = 1'b1;
      // R10 reset state read through R9 moves
      step(20, 0, 0, 0, 0, 0);
      step(21, 0, 0, 0, 0, 0);
      // R1 wrap-around and sign-extended immediate
      step(0, 32'h7fffffff, 32'h1, 0, 0, 0);
      step(0, 32'hffffffff, 32'hffffffff, 0, 0, 0);
      step(1, 32'h0, 32'h1, 0, 0, 0);
      step(11, 32'h5, 0, 16'hfff6, 0, 0);
      step(11, 32'hffffffff, 0, 16'h7fff, 0, 0);
      // R2 register and zero-extended immediate logic
      step(2, 32'hf0f0ff00, 32'h0ff0f0f0, 0, 0, 0);
      step(3, 32'hf0f0ff00, 32'h0ff0f0f0, 0, 0, 0);
      step(4, 32'hf0f0ff00, 32'h0ff0f0f0, 0, 0, 0);
      step(12, 32'hffffffff, 0, 16'h8000, 0, 0);
      step(13, 32'h0, 0, 16'h8001, 0, 0);
      step(14, 32'h12345678, 0, 16'hffff, 0, 0);
      // R3 fixed shifts, logical right fill
      step(5, 0, 32'h1, 0, 31, 0);
      step(6, 0, 32'h80000000, 0, 31, 0);
      step(6, 0, 32'hdeadbeef, 0, 0, 0);
      // R4 variable shifts use only the low five bits of A
      step(7, 32'h00000023, 32'h1, 0, 0, 0);
      step(8, 32'hffffffe1, 32'h80000000, 0, 0, 0);
      step(8, 32'hffffffe0, 32'h80000000, 0, 0, 0);
      // R5 signed versus unsigned register compare
      step(9, 32'hffffffff, 32'h1, 0, 0, 0);
      step(10, 32'hffffffff, 32'h1, 0, 0, 0);
      step(9, 32'h5, 32'h5, 0, 0, 0);
      // R6 immediate compares
      step(15, 32'hfffffffe, 0, 16'hffff, 0, 0);
      step(15, 32'h00010000, 0, 16'hffff, 0, 0);
      step(16, 32'h00010000, 0, 16'hffff, 0, 0);
      step(16, 32'h00000005, 0, 16'hffff, 0, 0);
      // R7 upper immediate
      step(17, 32'hffffffff, 32'hffffffff, 16'h1234, 0, 0);
      // R8 signed multiply with a negative operand
      step(18, 32'hfffffffd, 32'h5, 0, 0, 1);
      step(20, 0, 0, 0, 0, 0);
      step(21, 0, 0, 0, 0, 0);
      // R8 unsigned multiply
      step(19, 32'hffffffff, 32'h2, 0, 0, 1);
      step(20, 0, 0, 0, 0, 0);
      step(21, 0, 0, 0, 0, 0);
      // R10 multiply with enable low leaves HI and LO untouched
      step(18, 32'h11111111, 32'h22222222, 0, 0, 0);
      step(20, 0, 0, 0, 0, 0);
      step(21, 0, 0, 0, 0, 0);
      // R11 unassigned code returns zero
      step(25, 32'hffffffff, 32'hffffffff, 16'hffff, 5, 0);
      step(31, 32'h1, 32'h1, 16'h1, 1, 1);
      // mixed traffic against the reference model
      for (int n = 0; n < 400; n++) begin
         step($urandom_range(0, 31), $urandom, $urandom, $urandom, $urandom_range(0, 31),
              $urandom_range(0, 1) == 1);
      end
      finish_run();
   end
endmodule